// File: doc/BRIEF.md
# Bit-Level Select-High SPI Slave

This block is a serial slave for a four-wire link whose select line is active high. Every transfer is one fixed-length frame. The master first sends a short header: a start bit, a direction bit and a target bit. An 8-bit payload follows, and a single trailing flag bit closes the frame. The flag reports whether read data is new or a repeat, or whether a write was taken or must be tried again.

On the chip side, the block owns two one-byte holding registers:

- A receive register that the frame logic fills and the local logic drains with a one-cycle pop.
- A transmit register that the local logic loads with a one-cycle push and the frame logic consumes.

A status read returns a small occupancy byte. It lets the master poll both registers without touching either one.

The serial pins are brought into the system clock domain through a synchronizer chain. Rising edges of the serial clock are detected there, so the serial clock must run well below the system clock.

Top module: `bitspi_slave`

## Requirements
- R1: After reset, `miso`, `rxFull` and `txFresh` are 0.
- R2: The select is active high, and every bit is taken on a rising edge of `sclk` while select is high. Within a frame the edges are used as follows:
  - Edge 0 carries the start bit, which must be 1.
  - Edge 1 carries the direction bit: 1 is a read, 0 is a write.
  - Edge 2 carries the target bit: 0 is data, 1 is status.
  - Edges 3 to 10 carry the payload, MSB first.
  - The trailing flag is sampled by the master at edge 11.
- R3: A data write into an empty receive register stores the payload, sets `rxFull`, and returns a trailing flag of 0.
- R4: A data write while `rxFull` is 1 returns a trailing flag of 1 and leaves `rxData` unchanged.
- R5: A data read while `txFresh` is 1 shifts out the transmit byte MSB first, returns a trailing flag of 0, and clears `txFresh`.
- R6: A data read while `txFresh` is 0 repeats the last transmit byte and returns a trailing flag of 1.
- R7: A status read returns a byte with `rxFull` in bit 0, `txFresh` in bit 1 and zeros above, followed by a trailing flag of 0. It changes neither register.
- R8: Dropping the select ends the frame at once. A write cut off before edge 10 stores nothing. The next frame starts from edge 0 only after the select has been low for at least one clock.
- R9: A frame whose start bit is 0 is ignored until the select falls. It stores nothing, consumes nothing and keeps `miso` at 0.
- R10: A byte pushed with `txPush` is never lost to a read that starts in the same cycle. Either that read returns it with a flag of 0, or it stays fresh for the next read.
- R11: `rxPop` clears `rxFull`, after which a new write is accepted.
- R12: `miso` is 0 while the select is low and after the trailing flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| ss | input | 1 | Active-high select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| rxData | output | 8 | Receive holding register |
| rxFull | output | 1 | Receive register holds an unread byte |
| rxPop | input | 1 | One-cycle pulse that frees the receive register |
| txData | input | 8 | Byte offered to the transmit register |
| txPush | input | 1 | One-cycle pulse that loads `txData` and marks it fresh |
| txFresh | output | 1 | Transmit register holds a byte not yet read |

## Verification
Two events can fall in the same system clock cycle:

- A local `txPush`.
- The header decode of a data read, which copies the transmit register into the shifter and clears its fresh mark.

The bench provokes the overlap by pulsing `txPush` at eight successive cycle offsets around the detected third `sclk` rise. Each offset runs in its own read frame, and that frame is followed by a second read. An offset is judged correct when one of two outcomes holds:

- The first read returns the new byte with a flag of 0, and the second read repeats it with a flag of 1.
- The first read returns the previous byte, and the second read returns the new byte with a flag of 0.

A release of the receive register in the same cycle as a write commit is covered by the rule that a pop frees the slot for that commit.

// File: rtl/bitspi_pkg.sv
package bitspi_pkg;

  // Strobes the frame control hands to the datapath, one per system clock.
  typedef struct packed {
    logic clear;      // select low: quiet the output
    logic loadTx;     // data-read header decoded: take transmit byte
    logic loadStat;   // status-read header decoded: take occupancy byte
    logic shiftOut;   // present next read bit
    logic shiftIn;    // capture a write bit
    logic driveStat;  // present read trailing flag
    logic commitWr;   // last write bit: try to store and present flag
    logic endBit;     // after the trailing flag
  } ctlStrobe_t;

endpackage

// File: rtl/bitspi_ctrl.sv
module bitspi_ctrl
  import bitspi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_LEN  = DATA_W + 4,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             ss,
  input  logic             mosi,
  output logic             mosiS,
  output logic [CNT_W-1:0] bitCnt,
  output ctlStrobe_t       stb
);

  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(2);
  localparam logic [CNT_W-1:0] DAT_FIRST = CNT_W'(3);
  localparam logic [CNT_W-1:0] DAT_LAST  = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] TRAIL     = CNT_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0] DONE      = CNT_W'(FRAME_LEN);

  logic [SYNC_STAGES-1:0] sclkSync, ssSync, mosiSync;
  logic sclkPrev, ssS, sclkRise, dead, rwReg, addrReg, live;

  // Synchronizer chains for each serial pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      ssSync   <= '0;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      ssSync   <= {ssSync[SYNC_STAGES-2:0], ss};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign ssS      = ssSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign sclkRise = sclkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign live     = ssS & sclkRise & ~dead & (bitCnt != DONE);

  // Edge counter and header capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      dead    <= 1'b0;
      rwReg   <= 1'b0;
      addrReg <= 1'b0;
    end else if (!ssS) begin
      bitCnt <= '0;
      dead   <= 1'b0;
    end else if (live) begin
      if (bitCnt == '0 && !mosiS) dead <= 1'b1;
      else                        bitCnt <= bitCnt + 1'b1;
      if (bitCnt == CNT_W'(1)) rwReg   <= mosiS;
      if (bitCnt == HDR_LAST)  addrReg <= mosiS;
    end
  end

  // Strobe decode
  always_comb begin
    stb           = '0;
    stb.clear     = ~ssS;
    stb.loadTx    = live && bitCnt == HDR_LAST && rwReg && !mosiS;
    stb.loadStat  = live && bitCnt == HDR_LAST && rwReg && mosiS;
    stb.shiftOut  = live && rwReg && bitCnt >= DAT_FIRST && bitCnt < DAT_LAST;
    stb.driveStat = live && rwReg && bitCnt == DAT_LAST;
    stb.shiftIn   = live && !rwReg && !addrReg &&
                    bitCnt >= DAT_FIRST && bitCnt <= DAT_LAST;
    stb.commitWr  = live && !rwReg && !addrReg && bitCnt == DAT_LAST;
    stb.endBit    = live && bitCnt == TRAIL;
  end

endmodule

// File: rtl/bitspi_datapath.sv
module bitspi_datapath
  import bitspi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              mosiS,
  input  logic              rxPop,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              txFresh,
  output logic              miso
);

  logic [DATA_W-1:0] shiftReg, txBuf, statusByte, inByte;
  logic statBit, rxAccept;

  assign statusByte = {{(DATA_W-2){1'b0}}, txFresh, rxFull};
  assign inByte     = {shiftReg[DATA_W-2:0], mosiS};
  assign rxAccept   = ~rxFull | rxPop;

  // Transmit holding register: a push wins over consumption
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txFresh <= 1'b0;
    end else if (txPush) begin
      txBuf   <= txData;
      txFresh <= 1'b1;
    end else if (stb.loadTx) begin
      txFresh <= 1'b0;
    end
  end

  // Receive holding register: a pop frees the slot for a same-cycle commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
    end else if (stb.commitWr && rxAccept) begin
      rxData <= inByte;
      rxFull <= 1'b1;
    end else if (rxPop) begin
      rxFull <= 1'b0;
    end
  end

  // Shared shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      statBit  <= 1'b0;
    end else if (stb.loadTx) begin
      shiftReg <= txBuf;
      statBit  <= ~txFresh;
    end else if (stb.loadStat) begin
      shiftReg <= statusByte;
      statBit  <= 1'b0;
    end else if (stb.shiftOut) begin
      shiftReg <= shiftReg << 1;
    end else if (stb.shiftIn) begin
      shiftReg <= inByte;
    end
  end

  // Serial output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              miso <= 1'b0;
    else if (stb.clear)     miso <= 1'b0;
    else if (stb.loadTx)    miso <= txBuf[DATA_W-1];
    else if (stb.loadStat)  miso <= statusByte[DATA_W-1];
    else if (stb.shiftOut)  miso <= shiftReg[DATA_W-2];
    else if (stb.driveStat) miso <= statBit;
    else if (stb.commitWr)  miso <= ~rxAccept;
    else if (stb.endBit)    miso <= 1'b0;
  end

endmodule

// File: rtl/bitspi_slave.sv
module bitspi_slave
  import bitspi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_LEN  = DATA_W + 4,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              ss,
  input  logic              mosi,
  output logic              miso,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  input  logic              rxPop,
  input  logic [DATA_W-1:0] txData,
  input  logic              txPush,
  output logic              txFresh
);

  ctlStrobe_t       stb;
  logic             mosiS;
  logic [CNT_W-1:0] bitCnt;

  bitspi_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ss(ss), .mosi(mosi),
    .mosiS(mosiS), .bitCnt(bitCnt), .stb(stb)
  );

  bitspi_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(mosiS),
    .rxPop(rxPop), .txPush(txPush), .txData(txData),
    .rxData(rxData), .rxFull(rxFull), .txFresh(txFresh), .miso(miso)
  );

endmodule

// File: rtl/bitspi_slave_chk.sv
module bitspi_slave_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ss,
  input logic              miso,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              rxPop,
  input logic              txPush,
  input logic              txFresh,
  input logic [CNT_W-1:0]  bitCnt
);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!ss && $past(!ss) && $past(!ss, 2) && $past(!ss, 3)) |-> !miso);

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxPop) |=> (rxFull && $stable(rxData)));

  assert_rx_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(rxPop));

  assert_tx_fresh_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFresh) |-> $past(txPush));

  assert_push_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    txPush |=> txFresh);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W + 4));

endmodule

bind bitspi_slave bitspi_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ss(ss), .miso(miso), .rxData(rxData),
  .rxFull(rxFull), .rxPop(rxPop), .txPush(txPush), .txFresh(txFresh),
  .bitCnt(bitCnt)
);

// File: tb/bitspi_slave_tb.sv
module bitspi_slave_tb;

  logic clk = 0, rstN = 0, sclk = 0, ss = 0, mosi = 0;
  logic rxPop = 0, txPush = 0;
  logic [7:0] txData = 0;
  logic miso, rxFull, txFresh;
  logic [7:0] rxData;
  int checks = 0, fails = 0;
  bit pushArm = 0;
  int pushOff = 0;
  logic [7:0] pushByte = 0;

  always #4 clk = ~clk;

  bitspi_slave u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ss(ss), .mosi(mosi), .miso(miso),
    .rxData(rxData), .rxFull(rxFull), .rxPop(rxPop), .txData(txData),
    .txPush(txPush), .txFresh(txFresh)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: nEdges rising sclk edges, reads sampled just before each edge
  task automatic frame(input bit st, input bit rw, input bit ad, input logic [7:0] wb,
                       input int nEdges, output logic [7:0] rb, output logic tb);
    rb = 0; tb = 0;
    ss = 1;
    waitN(4);
    for (int e = 0; e < nEdges; e++) begin
      case (e)
        0: mosi = st;
        1: mosi = rw;
        2: mosi = ad;
        default: mosi = (e <= 10) ? wb[10-e] : 1'b0;
      endcase
      waitN(4);
      if (e >= 3 && e <= 10) rb[10-e] = miso;
      if (e == 11) tb = miso;
      sclk = 1;
      if (e == 2 && pushArm) begin
        for (int c = 0; c < 8; c++) begin
          if (c == pushOff) begin txData = pushByte; txPush = 1; end
          @(negedge clk);
          txPush = 0;
        end
      end else begin
        waitN(4);
      end
      sclk = 0;
    end
    waitN(4);
    ss = 0;
    mosi = 0;
    waitN(6);
  endtask

  task automatic push(input logic [7:0] b);
    txData = b; txPush = 1; @(negedge clk); txPush = 0; waitN(1);
  endtask

  task automatic pop();
    rxPop = 1; @(negedge clk); rxPop = 0; waitN(1);
  endtask

  task automatic testReset();
    chk(miso == 0, "R1", "miso", miso, 0);
    chk(rxFull == 0, "R1", "rxFull", rxFull, 0);
    chk(txFresh == 0, "R1", "txFresh", txFresh, 0);
  endtask

  task automatic testWrite();
    logic [7:0] rb; logic tb;
    frame(1, 0, 0, 8'hA5, 12, rb, tb);
    chk(tb == 0, "R3", "write flag", tb, 0);
    chk(rxFull == 1, "R3", "rxFull", rxFull, 1);
    chk(rxData == 8'hA5, "R3", "rxData", rxData, 8'hA5);
    chk(miso == 0, "R12", "miso after frame", miso, 0);
  endtask

  task automatic testWriteFull();
    logic [7:0] rb; logic tb;
    frame(1, 0, 0, 8'h3C, 12, rb, tb);
    chk(tb == 1, "R4", "retry flag", tb, 1);
    chk(rxData == 8'hA5, "R4", "rxData kept", rxData, 8'hA5);
    pop();
    chk(rxFull == 0, "R11", "rxFull after pop", rxFull, 0);
    frame(1, 0, 0, 8'h3C, 12, rb, tb);
    chk(tb == 0 && rxData == 8'h3C, "R11", "write after pop", rxData, 8'h3C);
  endtask

  task automatic testRead();
    logic [7:0] rb; logic tb;
    push(8'h96);
    frame(1, 1, 0, 8'h00, 12, rb, tb);
    chk(rb == 8'h96, "R5", "read byte", rb, 8'h96);
    chk(tb == 0, "R5", "fresh flag", tb, 0);
    chk(txFresh == 0, "R5", "txFresh cleared", txFresh, 0);
    frame(1, 1, 0, 8'h00, 12, rb, tb);
    chk(rb == 8'h96, "R6", "repeated byte", rb, 8'h96);
    chk(tb == 1, "R6", "stale flag", tb, 1);
  endtask

  task automatic testStatus();
    logic [7:0] rb; logic tb;
    push(8'h11);
    frame(1, 1, 1, 8'h00, 12, rb, tb);
    chk(rb == 8'h03, "R7", "status both", rb, 8'h03);
    chk(tb == 0, "R7", "status trailing", tb, 0);
    chk(txFresh == 1 && rxFull == 1, "R7", "status no side effect",
        {txFresh, rxFull}, 3);
    pop();
    frame(1, 1, 1, 8'h00, 12, rb, tb);
    chk(rb == 8'h02, "R7", "status tx only", rb, 8'h02);
  endtask

  task automatic testAbort();
    logic [7:0] rb; logic tb;
    frame(1, 0, 0, 8'h5A, 10, rb, tb);
    chk(rxFull == 0, "R8", "cut write stored nothing", rxFull, 0);
    chk(miso == 0, "R12", "miso with select low", miso, 0);
    frame(1, 0, 0, 8'h77, 12, rb, tb);
    chk(rxFull == 1 && rxData == 8'h77, "R8", "next frame after gap", rxData, 8'h77);
    pop();
  endtask

  task automatic testBadStart();
    logic [7:0] rb; logic tb;
    frame(0, 1, 0, 8'h00, 12, rb, tb);
    chk(rb == 0 && tb == 0, "R9", "quiet output", {rb, tb}, 0);
    chk(txFresh == 1, "R9", "tx not consumed", txFresh, 1);
    frame(0, 0, 0, 8'hFF, 12, rb, tb);
    chk(rxFull == 0, "R9", "no store", rxFull, 0);
  endtask

  task automatic testCollision();
    logic [7:0] r1, r2; logic t1, t2;
    for (int off = 0; off < 8; off++) begin
      push(8'h40 + 8'(off));
      pushByte = 8'hC0 + 8'(off);
      pushOff = off;
      pushArm = 1;
      frame(1, 1, 0, 8'h00, 12, r1, t1);
      pushArm = 0;
      frame(1, 1, 0, 8'h00, 12, r2, t2);
      chk(t1 == 0 && ((r1 == pushByte && r2 == pushByte && t2 == 1) ||
                      (r1 == 8'h40 + 8'(off) && r2 == pushByte && t2 == 0)),
          "R10", $sformatf("push offset %0d (r1 then r2)", off),
          {r1, r2}, {pushByte, pushByte});
    end
  endtask

  task automatic runAll();
    waitN(3);
    rstN = 1;
    waitN(3);
    testReset();
    testWrite();
    testWriteFull();
    testRead();
    testStatus();
    testAbort();
    testBadStart();
    testCollision();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule